// File: doc/BRIEF.md
# Board Control Register Bank with Encoded Single-Bit Updates

This block is a byte-wide register bank for board glue logic on a processor's external bus. It decodes a 4 KB window and drives a vector of discrete control lines. These lines are peripheral resets, power enables, a backlight enable and an active-low sleep line. Software never has to read, modify and write the control vector. Each write to the command offset carries a bit index and a set-or-clear choice in one byte, so exactly one line changes per write.

The command byte has two forms. If the low nibble is all ones, the bit named by the high nibble is set. If the high nibble is all ones, the bit named by the low nibble is cleared. A read of the command offset returns a fixed version byte, not the control vector. The bank also holds two general read/write bytes and a switch-input port. The switch-input offset also accepts a write-only serial-port configuration byte. Read data is registered and appears in the cycle after the read strobe.

Top module: `board_ctl_regs`

## Requirements
- R1: A write (cs and wr_en high) of byte B to offset 0x06, where B[3:0] is 0xF and B[7:4] is below N_CTL, sets ctl_out[B[7:4]] to 1 at the next clock edge.
- R2: A write of byte B to offset 0x06, where B[7:4] is 0xF and B[3:0] is below N_CTL, clears ctl_out[B[3:0]] to 0 at the next clock edge.
- R3: A byte written to 0x06 is ignored, leaving ctl_out unchanged, in two cases: it fits neither nibble form, or its index is N_CTL or above (index 10 to 15 by default). The byte 0xFF counts as ignored.
- R4: A write to 0x06 changes at most one bit of ctl_out. ctl_out changes only on a write to 0x06.
- R5: A read (cs and rd_en high) of offset 0x06 returns VERSION (default 0xA3) on rdata in the next cycle.
- R6: While rst_n is low, ctl_out equals CTL_INIT (default 0x287). In that value the resets at bits 0, 1, 7 and 9 are asserted, camera power-down (bit 2) is asserted, and the active-low sleep line (bit 8) is low. reg_a_out, reg_b_out, uart_cfg and rdata are 0x00 during reset.
- R7: Offsets 0x00 and 0x04 hold plain bytes, shown on reg_a_out and reg_b_out. A write updates the byte at the next edge, and a read returns it in the next cycle.
- R8: A read of offset 0x02 returns sw_in as it was at the read strobe. A write to 0x02 loads uart_cfg and does not alter what that offset reads.
- R9: Any offset other than 0x00, 0x02, 0x04 and 0x06, odd offsets included, reads as 0x00 and ignores writes.
- R10: With cs low, wr_en and rd_en have no effect. rdata is 0x00 in every cycle that does not follow a selected read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Window chip select |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (12) | Byte offset inside the window |
| wdata | input | 8 | Write data byte |
| sw_in | input | 8 | Board switch inputs |
| rdata | output | 8 | Registered read data |
| ctl_out | output | N_CTL (10) | Discrete control lines |
| reg_a_out | output | 8 | General byte at 0x00 |
| reg_b_out | output | 8 | General byte at 0x04 |
| uart_cfg | output | 8 | Write-only serial configuration byte at 0x02 |

## Verification
Every stored bit drives a port directly, so a corrupted control vector is visible one edge after the command that caused it. Two examples: a wrongly built bit mask shows up as more than one changed line, and a lost update shows up as a line that did not move. A wrong address decode shows on rdata one cycle after the read strobe, because an offset that should be empty returns a nonzero byte, or a general byte fails to read back. Walking every index through both nibble forms, together with the rejected byte patterns, leaves a bad index comparison no cycle in which to hide.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;
    localparam logic [NIB_W-1:0] NIB_ONES = '1;

    typedef enum logic [1:0] {
        SEL_GEN_A = 2'd0,
        SEL_SWUART = 2'd1,
        SEL_GEN_B = 2'd2,
        SEL_CMD    = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/bctl_addr_decode.sv
module bctl_addr_decode
    import board_ctl_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int OFS_A   = 0,
    parameter int OFS_SW  = 2,
    parameter int OFS_B   = 4,
    parameter int OFS_CMD = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output reg_sel_e          sel
);
    always_comb begin
        hit = 1'b1;
        sel = SEL_GEN_A;
        if (addr == ADDR_W'(OFS_A))        sel = SEL_GEN_A;
        else if (addr == ADDR_W'(OFS_SW))  sel = SEL_SWUART;
        else if (addr == ADDR_W'(OFS_B))   sel = SEL_GEN_B;
        else if (addr == ADDR_W'(OFS_CMD)) sel = SEL_CMD;
        else                               hit = 1'b0;
    end
endmodule

// File: rtl/bctl_cmd_decode.sv
module bctl_cmd_decode
    import board_ctl_pkg::*;
#(
    parameter int N_CTL = 10
) (
    input  logic [BYTE_W-1:0] cmd,
    output logic              upd,
    output logic              set_not_clr,
    output logic [N_CTL-1:0]  mask
);
    logic [NIB_W-1:0] hi_nib, lo_nib, idx;
    logic set_ok, clr_ok;

    always_comb begin
        hi_nib      = cmd[BYTE_W-1:NIB_W];
        lo_nib      = cmd[NIB_W-1:0];
        set_ok      = (lo_nib == NIB_ONES) && (int'(hi_nib) < N_CTL);
        clr_ok      = (hi_nib == NIB_ONES) && (int'(lo_nib) < N_CTL);
        upd         = set_ok || clr_ok;
        set_not_clr = set_ok;
        idx         = set_ok ? hi_nib : lo_nib;
    end

    for (genvar i = 0; i < N_CTL; i++) begin : g_mask
        assign mask[i] = (int'(idx) == i);
    end
endmodule

// File: rtl/bctl_rd_mux.sv
module bctl_rd_mux
    import board_ctl_pkg::*;
#(
    parameter logic [BYTE_W-1:0] VERSION = 8'hA3
) (
    input  logic              hit,
    input  reg_sel_e          sel,
    input  logic [BYTE_W-1:0] gen_a,
    input  logic [BYTE_W-1:0] sw,
    input  logic [BYTE_W-1:0] gen_b,
    output logic [BYTE_W-1:0] dout
);
    always_comb begin
        dout = '0;
        if (hit) begin
            unique case (sel)
                SEL_GEN_A:  dout = gen_a;
                SEL_SWUART: dout = sw;
                SEL_GEN_B:  dout = gen_b;
                SEL_CMD:    dout = VERSION;
                default:    dout = '0;
            endcase
        end
    end
endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs
    import board_ctl_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter int                N_CTL    = 10,
    parameter logic [N_CTL-1:0]  CTL_INIT = 10'h287,
    parameter logic [BYTE_W-1:0] VERSION  = 8'hA3,
    parameter int                OFS_A    = 0,
    parameter int                OFS_SW   = 2,
    parameter int                OFS_B    = 4,
    parameter int                OFS_CMD  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] sw_in,
    output logic [BYTE_W-1:0] rdata,
    output logic [N_CTL-1:0]  ctl_out,
    output logic [BYTE_W-1:0] reg_a_out,
    output logic [BYTE_W-1:0] reg_b_out,
    output logic [BYTE_W-1:0] uart_cfg
);
    typedef struct packed {
        logic [N_CTL-1:0]  ctl;
        logic [BYTE_W-1:0] gen_a;
        logic [BYTE_W-1:0] gen_b;
        logic [BYTE_W-1:0] uart;
        logic [BYTE_W-1:0] rdat;
    } state_t;

    localparam state_t STATE_RST = '{ctl: CTL_INIT, gen_a: '0, gen_b: '0,
                                     uart: '0, rdat: '0};

    state_t st_d, st_q;

    logic              hit;
    reg_sel_e          sel;
    logic              cmd_upd, cmd_set;
    logic [N_CTL-1:0]  cmd_mask;
    logic [BYTE_W-1:0] mux_out;

    bctl_addr_decode #(
        .ADDR_W(ADDR_W), .OFS_A(OFS_A), .OFS_SW(OFS_SW),
        .OFS_B(OFS_B), .OFS_CMD(OFS_CMD)
    ) u_dec (
        .addr(addr), .hit(hit), .sel(sel)
    );

    bctl_cmd_decode #(.N_CTL(N_CTL)) u_cmd (
        .cmd(wdata), .upd(cmd_upd), .set_not_clr(cmd_set), .mask(cmd_mask)
    );

    bctl_rd_mux #(.VERSION(VERSION)) u_rmux (
        .hit(hit), .sel(sel), .gen_a(st_q.gen_a), .sw(sw_in),
        .gen_b(st_q.gen_b), .dout(mux_out)
    );

    always_comb begin
        st_d      = st_q;
        st_d.rdat = (cs && rd_en) ? mux_out : '0;
        if (cs && wr_en && hit) begin
            unique case (sel)
                SEL_GEN_A:  st_d.gen_a = wdata;
                SEL_SWUART: st_d.uart  = wdata;
                SEL_GEN_B:  st_d.gen_b = wdata;
                SEL_CMD: begin
                    if (cmd_upd) begin
                        st_d.ctl = cmd_set ? (st_q.ctl | cmd_mask)
                                           : (st_q.ctl & ~cmd_mask);
                    end
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= STATE_RST;
        else        st_q <= st_d;
    end

    assign rdata     = st_q.rdat;
    assign ctl_out   = st_q.ctl;
    assign reg_a_out = st_q.gen_a;
    assign reg_b_out = st_q.gen_b;
    assign uart_cfg  = st_q.uart;
endmodule

// File: rtl/bctl_checker.sv
module bctl_checker #(
    parameter int         ADDR_W  = 12,
    parameter int         N_CTL   = 10,
    parameter logic [7:0] VERSION = 8'hA3,
    parameter int         OFS_A   = 0,
    parameter int         OFS_SW  = 2,
    parameter int         OFS_B   = 4,
    parameter int         OFS_CMD = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic [7:0]        sw_in,
    input logic [7:0]        rdata,
    input logic [N_CTL-1:0]  ctl_out,
    input logic [7:0]        reg_a_out
);
    logic cmd_wr, set_form, clr_form, known;
    assign cmd_wr   = cs && wr_en && (addr == ADDR_W'(OFS_CMD));
    assign set_form = (wdata[3:0] == 4'hF) && (int'(wdata[7:4]) < N_CTL);
    assign clr_form = (wdata[7:4] == 4'hF) && (int'(wdata[3:0]) < N_CTL);
    assign known    = (addr == ADDR_W'(OFS_A)) || (addr == ADDR_W'(OFS_SW)) ||
                      (addr == ADDR_W'(OFS_B)) || (addr == ADDR_W'(OFS_CMD));

    a_r1_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && set_form |=> ((ctl_out >> $past(wdata[7:4])) & N_CTL'(1)) != '0);

    a_r2_clr_bit: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && clr_form |=> ((ctl_out >> $past(wdata[3:0])) & N_CTL'(1)) == '0);

    a_r3_bad_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && !set_form && !clr_form |=> $stable(ctl_out));

    a_r4_one_bit_only: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $countones(ctl_out ^ $past(ctl_out)) <= 1);

    a_r4_no_cmd_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> $stable(ctl_out));

    a_r5_version_read: assert property (@(posedge clk) disable iff (!rst_n)
        cs && rd_en && (addr == ADDR_W'(OFS_CMD)) |=> rdata == VERSION);

    a_r7_gen_a_read: assert property (@(posedge clk) disable iff (!rst_n)
        cs && rd_en && (addr == ADDR_W'(OFS_A)) |=> rdata == $past(reg_a_out));

    a_r8_switch_read: assert property (@(posedge clk) disable iff (!rst_n)
        cs && rd_en && (addr == ADDR_W'(OFS_SW)) |=> rdata == $past(sw_in));

    a_r9_unused_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cs && rd_en && !known |=> rdata == 8'h00);

    a_r10_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && rd_en) |=> rdata == 8'h00);
endmodule

bind board_ctl_regs bctl_checker #(
    .ADDR_W(ADDR_W), .N_CTL(N_CTL), .VERSION(VERSION), .OFS_A(OFS_A),
    .OFS_SW(OFS_SW), .OFS_B(OFS_B), .OFS_CMD(OFS_CMD)
) u_bctl_checker (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .sw_in(sw_in), .rdata(rdata),
    .ctl_out(ctl_out), .reg_a_out(reg_a_out)
);

// File: tb/board_ctl_regs_bench.sv
module board_ctl_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [7:0]  wdata = '0, sw_in = 8'h00;
    logic [7:0]  rdata, reg_a_out, reg_b_out, uart_cfg;
    logic [9:0]  ctl_out;

    int checks = 0, failures = 0;
    bit done = 0;
    logic [9:0] exp_ctl;

    always #2.5 clk = ~clk;

    board_ctl_regs u_board_ctl_regs (
        .clk(clk), .rst_n(rst_n), .cs(cs), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .sw_in(sw_in), .rdata(rdata),
        .ctl_out(ctl_out), .reg_a_out(reg_a_out), .reg_b_out(reg_b_out),
        .uart_cfg(uart_cfg)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [7:0] d, input logic sel = 1'b1);
        @(negedge clk);
        cs = sel; wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; rd_en = 1'b1; addr = a;
        @(negedge clk);
        d = rdata;
        cs = 1'b0; rd_en = 1'b0;
    endtask

    task automatic t_reset;
        chk("R6 ctl reset", 32'(ctl_out), 32'h287);
        chk("R6 reg_a reset", 32'(reg_a_out), 0);
        chk("R6 reg_b reset", 32'(reg_b_out), 0);
        chk("R6 uart reset", 32'(uart_cfg), 0);
        chk("R6 rdata reset", 32'(rdata), 0);
        exp_ctl = 10'h287;
    endtask

    task automatic t_set_clear_sweep;
        for (int i = 0; i < 10; i++) begin
            bus_write(12'h006, {4'(i), 4'hF});
            exp_ctl[i] = 1'b1;
            chk("R1 set sweep", 32'(ctl_out), 32'(exp_ctl));
        end
        chk("R1 all set", 32'(ctl_out), 32'h3FF);
        for (int i = 0; i < 10; i++) begin
            bus_write(12'h006, {4'hF, 4'(i)});
            exp_ctl[i] = 1'b0;
            chk("R2 clear sweep", 32'(ctl_out), 32'(exp_ctl));
        end
        chk("R2 all clear", 32'(ctl_out), 0);
        bus_write(12'h006, 8'h6F); exp_ctl[6] = 1'b1;
        bus_write(12'h006, 8'h8F); exp_ctl[8] = 1'b1;
        bus_write(12'h006, 8'h6F);
        chk("R4 repeat set single bit", 32'(ctl_out), 32'(exp_ctl));
    endtask

    task automatic t_bad_cmds;
        logic [7:0] bad [8] = '{8'hFF, 8'hAF, 8'hEF, 8'hFA, 8'hFC, 8'h55, 8'h00, 8'h3E};
        foreach (bad[k]) begin
            bus_write(12'h006, bad[k]);
            chk("R3 bad command ignored", 32'(ctl_out), 32'(exp_ctl));
        end
    endtask

    task automatic t_gen_regs;
        logic [7:0] d;
        bus_write(12'h000, 8'h5A);
        chk("R7 reg_a out", 32'(reg_a_out), 32'h5A);
        bus_write(12'h004, 8'hC3);
        chk("R7 reg_b out", 32'(reg_b_out), 32'hC3);
        bus_read(12'h000, d); chk("R7 reg_a read", 32'(d), 32'h5A);
        bus_read(12'h004, d); chk("R7 reg_b read", 32'(d), 32'hC3);
        chk("R4 no ctl change on other writes", 32'(ctl_out), 32'(exp_ctl));
    endtask

    task automatic t_switch_uart;
        logic [7:0] d;
        sw_in = 8'h96;
        bus_write(12'h002, 8'h21);
        chk("R8 uart_cfg loaded", 32'(uart_cfg), 32'h21);
        bus_read(12'h002, d); chk("R8 switch read", 32'(d), 32'h96);
        sw_in = 8'h3C;
        bus_read(12'h002, d); chk("R8 switch read 2", 32'(d), 32'h3C);
    endtask

    task automatic t_version;
        logic [7:0] d;
        bus_read(12'h006, d); chk("R5 version read", 32'(d), 32'hA3);
        chk("R5 read leaves ctl", 32'(ctl_out), 32'(exp_ctl));
    endtask

    task automatic t_unused;
        logic [7:0] d;
        bus_write(12'h008, 8'h77);
        bus_write(12'h001, 8'h77);
        bus_write(12'h106, 8'h0F);
        chk("R9 unused write: ctl", 32'(ctl_out), 32'(exp_ctl));
        chk("R9 unused write: reg_a", 32'(reg_a_out), 32'h5A);
        chk("R9 unused write: reg_b", 32'(reg_b_out), 32'hC3);
        bus_read(12'h008, d); chk("R9 read 0x08", 32'(d), 0);
        bus_read(12'h001, d); chk("R9 read odd 0x01", 32'(d), 0);
        bus_read(12'hFFE, d); chk("R9 read 0xFFE", 32'(d), 0);
    endtask

    task automatic t_no_select;
        bus_write(12'h006, 8'h0F, 1'b0);
        chk("R10 cs low cmd ignored", 32'(ctl_out), 32'(exp_ctl));
        bus_write(12'h000, 8'h11, 1'b0);
        chk("R10 cs low reg_a ignored", 32'(reg_a_out), 32'h5A);
        @(negedge clk);
        cs = 1'b0; rd_en = 1'b1; addr = 12'h006;
        @(negedge clk);
        chk("R10 rdata zero without cs", 32'(rdata), 0);
        rd_en = 1'b0;
        @(negedge clk);
        chk("R10 rdata idle zero", 32'(rdata), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        t_set_clear_sweep;
        t_bad_cmds;
        t_gen_regs;
        t_switch_uart;
        t_version;
        t_unused;
        t_no_select;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule